// File: doc/BRIEF.md
# Converter Serial Frame Interface

This block is the slave side of the serial link of a data converter. The host opens a frame by pulling the active-low select line `cs_n` low. While that line is low, the block shifts the 32-bit result word out on `sdo`, most significant bit first. At the same time it shifts a command word in from `sdi` and counts the serial clocks it receives. When `cs_n` goes high again, the output stops driving and a conversion starts. The block then sorts the frame by its clock count and issues a one-cycle command strobe.

- A frame of exactly 32 clocks, or of more than 32, delivers the last 32 bits received as the command.
- A frame of fewer than 32 clocks delivers the NOP word (all zeros). The leading output bits the host read during that frame are still valid.

`ready` is low for the whole frame and during the conversion that follows it. It returns high once a conversion time, counted in system clock cycles, has passed. The host must not start a frame while `ready` is low, and the block ignores a select edge that arrives then.

Serial timing is SPI mode 0: input is captured on the rising `sclk` edge and output is launched on the falling edge. All serial inputs pass through synchronizers into the `clk` domain, so each `sclk` phase must last several `clk` cycles.

Top module: `cfi_frame_if`

## Requirements
- R1: After synchronous reset, `ready` is 1, `sdo_oe` is 0, `cmd_valid` is 0 and `cmd_word` is 0.
- R2: A falling `cs_n` while `ready` is 1 opens a frame. Within 4 clk cycles, `ready` goes 0, `sdo_oe` goes 1 and `cmd_word` reads 0 (the NOP word).
- R3: During a frame, `sdo` first shows bit 31 of `result_word` as captured at frame open. Each falling `sclk` edge advances it one bit toward bit 0. After all 32 bits have been shifted out, `sdo` shows 0.
- R4: On each rising `sclk` edge in a frame, the synchronized `sdi` bit enters bit 0 of the input register and the older bits move up one place.
- R5: A frame with exactly 32 rising `sclk` edges yields `cmd_kind` = 1 (exact). `cmd_word` then holds the 32 received bits, with the first bit received in bit 31.
- R6: A frame with fewer than 32 rising `sclk` edges, including none at all, yields `cmd_kind` = 0 (short) and `cmd_word` = 0.
- R7: A frame with more than 32 rising `sclk` edges yields `cmd_kind` = 2 (long) and `cmd_word` = the last 32 bits received. The clock count saturates, so 64 or 96 clocks still classify as long.
- R8: After `cs_n` rises, `sdo_oe` drops within 4 clk cycles. `ready` stays 0 for at least CONV_CYCLES clk cycles and returns to 1 within CONV_CYCLES+8 cycles.
- R9: A falling `cs_n` while `ready` is 0 does not open a frame. `sdo_oe` stays 0, no `cmd_valid` pulse follows the matching rise, and `ready` returns high on the original schedule.
- R10: Each closed frame produces exactly one `cmd_valid` pulse, one clk cycle wide, within 8 clk cycles of `cs_n` rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select; its rising edge starts a conversion |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial command data from the host |
| result_word | input | 32 | Conversion result loaded at frame open |
| sdo | output | 1 | Serial result data, MSB first |
| sdo_oe | output | 1 | Output enable for `sdo` (0 = high impedance) |
| ready | output | 1 | 1 when idle, 0 during a frame and a conversion |
| cmd_valid | output | 1 | One-cycle strobe when a frame closes |
| cmd_word | output | 32 | Command word delivered at close, 0 for NOP |
| cmd_kind | output | 2 | Frame class: 0 short, 1 exact, 2 long |

## Verification
The hardest case to reach from the ports is a saturated clock count. Without saturation, a 6-bit counter would wrap: a 64-clock frame would read as short and a 96-clock frame as exact. The vector table therefore includes frames of 64 and 96 clocks, each driven from a long repeating bit pattern. A second awkward case is a select edge that arrives during a conversion. To produce it, the bench drops `cs_n` and toggles `sclk` right after a frame has closed, while `ready` is still low. It then checks that no frame opens and that `ready` still rises on time.

// File: rtl/cfi_pkg.sv
package cfi_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        FR_SHORT = 2'd0,
        FR_EXACT = 2'd1,
        FR_LONG  = 2'd2
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e         kind;
        logic [WORD_W-1:0]   word;
    } cmd_t;

    localparam logic [WORD_W-1:0] NOP_WORD = '0;

    function automatic frame_kind_e classify(int unsigned n);
        if (n < WORD_W)       return FR_SHORT;
        else if (n == WORD_W) return FR_EXACT;
        else                  return FR_LONG;
    endfunction

endpackage

// File: rtl/cfi_sync.sv
module cfi_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    input  logic [N-1:0] rst_val,
    output logic [N-1:0] q
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{rst_val[b]}};
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/cfi_edge.sv
module cfi_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level,
    input  logic [N-1:0] rst_val,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= rst_val;
        else     prev <= level;
    end

    for (genvar b = 0; b < N; b++) begin : g_edge
        assign rise[b] =  level[b] & ~prev[b];
        assign fall[b] = ~level[b] &  prev[b];
    end
endmodule

// File: rtl/cfi_shifter.sv
module cfi_shifter
    import cfi_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int CNT_W = $clog2(2 * W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             active,
    input  logic             cap_edge,
    input  logic             launch_edge,
    input  logic             sdi_s,
    input  logic [W-1:0]     load_word,
    output logic             out_bit,
    output logic [W-1:0]     in_word,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [W-1:0] osr;

    always_ff @(posedge clk) begin
        if (rst) begin
            osr     <= '0;
            in_word <= '0;
            count   <= '0;
        end else if (frame_start) begin
            osr     <= load_word;
            in_word <= '0;
            count   <= '0;
        end else if (active) begin
            if (launch_edge)
                osr <= {osr[W-2:0], 1'b0};
            if (cap_edge) begin
                in_word <= {in_word[W-2:0], sdi_s};
                if (count != CNT_MAX)
                    count <= count + 1'b1;
            end
        end
    end

    assign out_bit = osr[W-1];

    a_r7_count_sat: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == CNT_MAX && !$past(frame_start) && !$past(rst)) |-> count == CNT_MAX);

    a_r2_count_clear: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> count == '0);

    a_r4_cap_moves: assert property (@(posedge clk) disable iff (rst)
        (active && cap_edge && !frame_start) |=> in_word[0] == $past(sdi_s));
endmodule

// File: rtl/cfi_conv_timer.sv
module cfi_conv_timer #(
    parameter int CONV_CYCLES = 100,
    parameter int CW          = $clog2(CONV_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(CONV_CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    assign done = busy && (remain == '0) && !start;

    a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    a_r8_done_ends: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !busy || $past(start));
endmodule

// File: rtl/cfi_frame_if.sv
module cfi_frame_if
    import cfi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CONV_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [WORD_W-1:0] result_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              ready,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_word,
    output logic [1:0]        cmd_kind
);
    localparam int CNT_W = $clog2(2 * WORD_W);

    logic [2:0] lvl;
    logic [1:0] rise, fall;
    logic cs_s, sclk_s, sdi_s;

    cfi_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .d({sdi, sclk, cs_n}), .rst_val(3'b001), .q(lvl)
    );
    assign cs_s   = lvl[0];
    assign sclk_s = lvl[1];
    assign sdi_s  = lvl[2];

    cfi_edge #(.N(2)) u_edge (
        .clk(clk), .rst(rst),
        .level({sclk_s, cs_s}), .rst_val(2'b01),
        .rise(rise), .fall(fall)
    );

    logic in_frame, ready_q;
    logic frame_start, frame_end;
    logic out_bit;
    logic [WORD_W-1:0] in_word;
    logic [CNT_W-1:0]  count;
    logic conv_busy, conv_done;
    cmd_t cmd_q;

    assign frame_start = fall[0] && ready_q && !in_frame;
    assign frame_end   = rise[0] && in_frame;

    cfi_shifter #(.W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst(rst),
        .frame_start(frame_start), .active(in_frame),
        .cap_edge(rise[1]), .launch_edge(fall[1]),
        .sdi_s(sdi_s), .load_word(result_word),
        .out_bit(out_bit), .in_word(in_word), .count(count)
    );

    cfi_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(frame_end),
        .busy(conv_busy), .done(conv_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame  <= 1'b0;
            ready_q   <= 1'b1;
            cmd_valid <= 1'b0;
            cmd_q     <= '{kind: FR_SHORT, word: NOP_WORD};
        end else begin
            cmd_valid <= 1'b0;
            if (frame_start) begin
                in_frame   <= 1'b1;
                ready_q    <= 1'b0;
                cmd_q.word <= NOP_WORD;
            end else if (frame_end) begin
                in_frame   <= 1'b0;
                cmd_valid  <= 1'b1;
                cmd_q.kind <= classify(int'(count));
                cmd_q.word <= (classify(int'(count)) == FR_SHORT) ? NOP_WORD : in_word;
            end else if (conv_done) begin
                ready_q <= 1'b1;
            end
        end
    end

    assign sdo       = in_frame ? out_bit : 1'b0;
    assign sdo_oe    = in_frame;
    assign ready     = ready_q;
    assign cmd_word  = cmd_q.word;
    assign cmd_kind  = cmd_q.kind;

    a_r10_one_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    a_r6_short_nop: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == FR_SHORT) |-> cmd_word == NOP_WORD);

    a_r8_oe_busy: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> !ready);

    a_r9_open_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(sdo_oe)) |-> $past(ready));

    a_r8_ready_after_conv: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(ready)) |-> !conv_busy && !in_frame);
endmodule

// File: tb/sim_cfi_frame_if.sv
module sim_cfi_frame_if;
    localparam int CONV = 200;
    localparam int HP   = 6;
    localparam int NV   = 8;

    localparam int VEC_N [NV] = '{32, 8, 0, 40, 64, 96, 33, 31};
    localparam logic [31:0] VEC_RES [NV] = '{
        32'hA5C3_0F1E, 32'hF000_0001, 32'h1234_5678, 32'h8000_0000,
        32'hDEAD_BEEF, 32'h0F0F_F0F0, 32'h7FFF_FFFE, 32'h0000_0003};
    localparam logic [63:0] VEC_PAT [NV] = '{
        64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_00C5, 64'h0,
        64'hFFFF_FF00_CAFE_F00D, 64'h5555_AAAA_1357_9BDF,
        64'hC001_D00D_8421_1248, 64'h0000_0001_8000_0001,
        64'h0000_0000_7654_3210};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [31:0] result_word = '0;
    logic sdo, sdo_oe, ready, cmd_valid;
    logic [31:0] cmd_word;
    logic [1:0] cmd_kind;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    cfi_frame_if #(.SYNC_STAGES(2), .CONV_CYCLES(CONV)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .result_word(result_word), .sdo(sdo), .sdo_oe(sdo_oe),
        .ready(ready), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_kind(cmd_kind)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(int n, logic [31:0] res, logic [63:0] pat, bit probe_busy);
        int bad = 0;
        logic [63:0] bad_act = 0, bad_exp = 0;
        logic [31:0] exp_cmd;
        logic [1:0]  exp_kind;
        int t = 0;
        int pulses = 0;
        int viol = 0;
        result_word = res;
        cs_n = 1'b0;
        tick(HP);
        check(ready == 1'b0 && sdo_oe == 1'b1 && cmd_word == 32'h0, "R2",
              {ready, sdo_oe, cmd_word}, 64'h1_0000_0000);
        for (int i = 0; i < n; i++) begin
            logic e;
            e = (i < 32) ? res[31-i] : 1'b0;
            if (sdo !== e && bad == 0) begin
                bad_act = i * 2 + sdo;
                bad_exp = i * 2 + e;
            end
            if (sdo !== e) bad++;
            sdi = pat[(n-1-i) % 64];
            tick(2);
            sclk = 1'b1;
            tick(HP);
            sclk = 1'b0;
            tick(HP);
        end
        check(bad == 0, "R3 (2*bit+value)", bad_act, bad_exp);
        cs_n = 1'b1;
        result_word = ~res;
        while (!cmd_valid && t < 12) begin tick(1); t++; end
        exp_kind = (n < 32) ? 2'd0 : (n == 32) ? 2'd1 : 2'd2;
        exp_cmd  = (n < 32) ? 32'h0 : pat[31:0];
        check(cmd_valid == 1'b1 && t <= 8, "R10 strobe", t, 8);
        if (n < 32)
            check(cmd_word == exp_cmd && cmd_kind == exp_kind, "R6 short",
                  {cmd_kind, cmd_word}, {exp_kind, exp_cmd});
        else if (n == 32)
            check(cmd_word == exp_cmd && cmd_kind == exp_kind, "R4 R5 exact",
                  {cmd_kind, cmd_word}, {exp_kind, exp_cmd});
        else
            check(cmd_word == exp_cmd && cmd_kind == exp_kind, "R4 R7 long",
                  {cmd_kind, cmd_word}, {exp_kind, exp_cmd});
        tick(1); t++;
        check(cmd_valid == 1'b0, "R10 width", cmd_valid, 0);
        check(sdo_oe == 1'b0, "R8 oe off", sdo_oe, 0);
        if (probe_busy) begin
            cs_n = 1'b0;
            for (int k = 0; k < 3; k++) begin
                sdi = k[0];
                for (int c = 0; c < 2 + 2 * HP; c++) begin
                    if (c == 2) sclk = 1'b1;
                    if (c == 2 + HP) sclk = 1'b0;
                    tick(1); t++;
                    if (sdo_oe || cmd_valid) viol++;
                end
            end
            cs_n = 1'b1;
            for (int c = 0; c < 12; c++) begin
                tick(1); t++;
                if (sdo_oe || cmd_valid) pulses++;
            end
            check(viol == 0 && pulses == 0, "R9 ignored", viol + pulses, 0);
        end
        while (!ready && t < CONV + 40) begin tick(1); t++; end
        check(ready == 1'b1 && t >= CONV && t <= CONV + 8, "R8 ready time", t, CONV);
    endtask

    initial begin
        int wd = 0;
        while (!done_flag && wd < 200000) begin
            @(posedge clk);
            wd++;
        end
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(3);
        check(ready == 1'b1 && sdo_oe == 1'b0 && cmd_valid == 1'b0 && cmd_word == 32'h0,
              "R1 reset", {ready, sdo_oe, cmd_valid, cmd_word}, 64'h4_0000_0000);
        for (int v = 0; v < NV; v++)
            run_frame(VEC_N[v], VEC_RES[v], VEC_PAT[v], 1'b0);
        run_frame(32, 32'h3C3C_9669, 64'h0000_0000_F00D_BABE, 1'b1);
        run_frame(100, 32'hFFFF_FFFF, 64'hAAAA_5555_0BAD_C0DE, 1'b0);
        run_frame(1, 32'h8000_0000, 64'h1, 1'b0);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(2);
        check(ready == 1'b1 && cmd_word == 32'h0 && cmd_valid == 1'b0, "R1 re-reset",
              {ready, cmd_valid, cmd_word}, 64'h2_0000_0000);
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule